// File: doc/BRIEF.md
# CAN Fault Confinement and Status Register Block

This block holds the error-reporting state of a CAN protocol controller. The bit-level protocol engine sends it single-cycle event pulses: a frame sent successfully, a frame received successfully, and a bus fault. A bus fault carries a 3-bit fault code and a flag that says whether the node was transmitting when the fault happened. From these pulses the block keeps a transmit fault counter and a receive fault counter. It derives three condition flags from the counters: warning, passive and bus-off.

Software reaches the block through a 16-bit register port with four addresses:
- a control register, which holds the status-interrupt enable;
- a status register, which holds the three condition flags, two success bits and a 3-bit fault code;
- a counter register;
- an interrupt identifier register.

The status interrupt is raised when a status bit changes or when the fault code takes a new value. While it is pending it takes priority over any message-object interrupt, which arrives from outside as an identifier input. The fault code value 7 is a marker that software writes to mean "nothing has happened since I last looked". The hardware replaces the marker only when a new bus event occurs. Bus-off is left only by a reset of the block.

Top module: `can_fault_status`

## Requirements
- R1: After reset the four registers read as follows: control 0x0000, status 0x0007 (fault code 7, all other bits 0), counters 0x0000, identifier equal to the message-object identifier input. `irq_o` is 0 when that input is 0.
- R2: A valid fault while transmitting adds 8 to the transmit counter. A valid fault while receiving adds 1 to the receive counter. The receive counter stops at 127; a further receive fault at 127 sets the receive-passive flag. A valid fault stores its code in status bits 2:0.
- R3: A good transmit pulse lowers the transmit counter by 1, stopping at 0, and sets transmit-ok (status bit 3). A good receive pulse lowers the receive counter by 1, stopping at 0, clears the receive-passive flag and sets receive-ok (status bit 4). Either pulse writes fault code 0.
- R4: Status bit 6 (warning) is 1 exactly when either counter is 96 or more.
- R5: Status bit 5 (passive) is 1 exactly when the transmit counter is above 127 or the receive-passive flag is set.
- R6: A transmit fault that would take the transmit counter past 255 sets status bit 7 (bus-off) and the transmit counter reads 255. While bus-off is set, neither counter changes until reset.
- R7: A write to the status register has these effects:
  - a 0 in bit 3 or bit 4 clears transmit-ok or receive-ok;
  - a 1 in those bits leaves them as they are;
  - bits 7:5 are not writable;
  - bits 2:0 load the written value, so 7 stays until a hardware event replaces it.
- R8: The counter register holds the transmit counter in bits 7:0, the receive counter in bits 14:8 and the receive-passive flag in bit 15.
- R9: The status interrupt becomes pending only when control bit 0 is 1 and one of these occurs: a condition flag changes; a success pulse sets a success bit that was 0; a hardware event writes a fault code that differs from the stored one. `irq_o` is 1 when the status interrupt is pending or the message-object identifier input is nonzero.
- R10: Reading the status register clears the pending status interrupt. If a new cause arrives in the same cycle, the interrupt stays pending. The read returns the value held before the clear.
- R11: Reading the identifier register returns 0x8000 while the status interrupt is pending. Otherwise it returns the message-object identifier input.
- R12: A fault pulse whose code is 0 or 7 is ignored. A valid fault in the same cycle as a success pulse cancels both success pulses.
- R13: The register addresses are 0 control, 1 status, 2 counters and 3 identifier. Read data appears on `rdata_o` after the clock edge that samples `rd_en_i` and holds until the next read. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | Pulse: frame transmitted successfully |
| rx_done_i | input | 1 | Pulse: frame received successfully |
| bus_err_i | input | 1 | Pulse: bus fault detected |
| bus_err_code_i | input | 3 | Fault code: 1 stuff, 2 form, 3 acknowledge, 4 bit1, 5 bit0, 6 CRC |
| bus_err_tx_i | input | 1 | 1 if the node was transmitting when the fault occurred |
| obj_iid_i | input | 16 | Message-object interrupt identifier, 0 when none is pending |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt line |

## Verification
All results are due one clock edge after the stimulus:
- an event pulse or register write driven before edge k shows up in the counters, the status bits and the pending interrupt right after edge k;
- read data for a read strobed at edge k is valid right after edge k;
- `irq_o` additionally follows `obj_iid_i` combinationally.

The bench drives inputs just after a falling edge and samples at the following falling edge, one rising edge later. It advances its expected-state functions once per cycle, in the same order: it computes the read value from the state before the edge, then applies the update.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam int TEC_W  = 8;
  localparam int REC_W  = 7;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] CODE_NONE   = 3'd0;
  localparam logic [CODE_W-1:0] CODE_MARKER = 3'd7;

  localparam logic [ADDR_W-1:0] RA_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] RA_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] RA_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] RA_IID  = 2'd3;

  localparam logic [DATA_W-1:0] IID_STATUS = 16'h8000;

  typedef struct packed {
    logic boff;
    logic warn;
    logic pass;
  } fault_t;
endpackage

// File: rtl/can_fault_counters.sv
module can_fault_counters
  import can_fault_pkg::*;
#(
  parameter int TX_STEP  = 8,
  parameter int WARN_LIM = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_fault,
  input  logic             rx_fault,
  input  logic             tx_good,
  input  logic             rx_good,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic             rx_pass,
  output fault_t           flags_q,
  output fault_t           flags_d
);
  localparam int TEC_MAX  = (1 << TEC_W) - 1;
  localparam int PASS_LIM = (1 << (TEC_W - 1)) - 1;
  localparam logic [TEC_W-1:0] STEP_V  = TEC_W'(TX_STEP);
  localparam logic [REC_W-1:0] REC_TOP = '1;

  logic [TEC_W-1:0] tec_d;
  logic [REC_W-1:0] rec_d;
  logic             rp_d;
  logic             boff_d;

  always_comb begin
    tec_d  = tec;
    rec_d  = rec;
    rp_d   = rx_pass;
    boff_d = flags_q.boff;
    if (!flags_q.boff) begin
      if (tx_fault) begin
        if (int'(tec) + TX_STEP > TEC_MAX) begin
          boff_d = 1'b1;
          tec_d  = '1;
        end else begin
          tec_d = tec + STEP_V;
        end
      end else if (tx_good && tec != '0) begin
        tec_d = tec - 1'b1;
      end
      if (rx_fault) begin
        if (rec == REC_TOP) rp_d = 1'b1;
        else                rec_d = rec + 1'b1;
      end else if (rx_good) begin
        rp_d = 1'b0;
        if (rec != '0) rec_d = rec - 1'b1;
      end
    end
  end

  always_comb begin
    flags_d.boff = boff_d;
    flags_d.warn = (int'(tec_d) >= WARN_LIM) || (int'(rec_d) >= WARN_LIM);
    flags_d.pass = (int'(tec_d) > PASS_LIM) || rp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec     <= '0;
      rec     <= '0;
      rx_pass <= 1'b0;
      flags_q <= '0;
    end else begin
      tec     <= tec_d;
      rec     <= rec_d;
      rx_pass <= rp_d;
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/can_fault_statreg.sv
module can_fault_statreg
  import can_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [CODE_W-1:0] fault_code,
  input  logic [1:0]        good,
  input  logic              sw_wr,
  input  logic [1:0]        sw_ok_keep,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              irq_en,
  input  fault_t            flags_d,
  input  fault_t            flags_q,
  input  logic              rd_ack,
  output logic [1:0]        ok_q,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q
);
  logic [1:0]        ok_rise;
  logic              hw_upd;
  logic [CODE_W-1:0] hw_code;
  logic              cause;

  // One success bit per direction: index 0 transmit, index 1 receive.
  for (genvar i = 0; i < 2; i++) begin : g_ok
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      bit_q <= 1'b0;
      else if (good[i])                bit_q <= 1'b1;
      else if (sw_wr && !sw_ok_keep[i]) bit_q <= 1'b0;
    end
    assign ok_q[i]    = bit_q;
    assign ok_rise[i] = good[i] & ~bit_q;
  end

  assign hw_upd  = fault_valid | (|good);
  assign hw_code = fault_valid ? fault_code : CODE_NONE;
  assign cause   = (flags_d != flags_q) | (|ok_rise) |
                   (hw_upd && (hw_code != code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_MARKER;
      pend_q <= 1'b0;
    end else begin
      if (hw_upd)     code_q <= hw_code;
      else if (sw_wr) code_q <= sw_code;
      pend_q <= (irq_en & cause) | (pend_q & ~rd_ack);
    end
  end
endmodule

// File: rtl/can_fault_regif.sv
module can_fault_regif
  import can_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  input  logic [7:0]        status_byte,
  input  logic [DATA_W-1:0] cnt_word,
  input  logic              pend,
  input  logic [DATA_W-1:0] obj_iid,
  output logic              irq_en,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  assign stat_wr = wr_en && (addr == RA_STAT);
  assign stat_rd = rd_en && (addr == RA_STAT);

  always_comb begin
    unique case (addr)
      RA_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, irq_en};
      RA_STAT: rd_mux = {{(DATA_W-8){1'b0}}, status_byte};
      RA_CNT:  rd_mux = cnt_word;
      default: rd_mux = pend ? IID_STATUS : obj_iid;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_en && addr == RA_CTRL) irq_en <= wbit0;
      if (rd_en)                    rdata  <= rd_mux;
    end
  end
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import can_fault_pkg::*;
#(
  parameter int TX_STEP  = 8,
  parameter int WARN_LIM = 96
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_done_i,
  input  logic        rx_done_i,
  input  logic        bus_err_i,
  input  logic [2:0]  bus_err_code_i,
  input  logic        bus_err_tx_i,
  input  logic [15:0] obj_iid_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        irq_o
);
  logic             fault_valid;
  logic             tx_fault;
  logic             rx_fault;
  logic [1:0]       good;
  logic [TEC_W-1:0] tec;
  logic [REC_W-1:0] rec;
  logic             rx_pass;
  fault_t           flags_q;
  fault_t           flags_d;
  logic [1:0]       ok_q;
  logic [CODE_W-1:0] code_q;
  logic             pend;
  logic             irq_en;
  logic             stat_wr;
  logic             stat_rd;
  logic [7:0]       status_byte;
  logic [DATA_W-1:0] cnt_word;
  logic             unused_wdata;

  assign fault_valid = bus_err_i && (bus_err_code_i != CODE_NONE) &&
                       (bus_err_code_i != CODE_MARKER);
  assign tx_fault    = fault_valid && bus_err_tx_i;
  assign rx_fault    = fault_valid && !bus_err_tx_i;
  assign good[0]     = tx_done_i && !fault_valid;
  assign good[1]     = rx_done_i && !fault_valid;

  can_fault_counters #(.TX_STEP(TX_STEP), .WARN_LIM(WARN_LIM)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tx_fault(tx_fault), .rx_fault(rx_fault),
    .tx_good(good[0]), .rx_good(good[1]),
    .tec(tec), .rec(rec), .rx_pass(rx_pass),
    .flags_q(flags_q), .flags_d(flags_d)
  );

  can_fault_statreg u_stat (
    .clk(clk), .rst_n(rst_n),
    .fault_valid(fault_valid), .fault_code(bus_err_code_i), .good(good),
    .sw_wr(stat_wr), .sw_ok_keep(wdata_i[4:3]), .sw_code(wdata_i[2:0]),
    .irq_en(irq_en), .flags_d(flags_d), .flags_q(flags_q), .rd_ack(stat_rd),
    .ok_q(ok_q), .code_q(code_q), .pend_q(pend)
  );

  assign status_byte = {flags_q.boff, flags_q.warn, flags_q.pass, ok_q[1], ok_q[0], code_q};
  assign cnt_word    = {rx_pass, rec, tec};

  can_fault_regif u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i), .wbit0(wdata_i[0]),
    .status_byte(status_byte), .cnt_word(cnt_word), .pend(pend),
    .obj_iid(obj_iid_i), .irq_en(irq_en), .stat_wr(stat_wr),
    .stat_rd(stat_rd), .rdata(rdata_o)
  );

  assign irq_o        = pend | (obj_iid_i != '0);
  assign unused_wdata = ^{wdata_i[15:5]};
endmodule

// File: rtl/can_fault_status_chk.sv
module can_fault_status_chk
  import can_fault_pkg::*;
#(
  parameter int TX_STEP  = 8,
  parameter int WARN_LIM = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_fault,
  input logic [TEC_W-1:0] tec,
  input logic [REC_W-1:0] rec,
  input logic             rx_pass,
  input fault_t           flags_q,
  input logic             pend,
  input logic             irq_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [15:0]      rdata
);
  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fault && !flags_q.boff && (int'(tec) + TX_STEP <= 255))
    |=> (tec == $past(tec) + 8'(TX_STEP)));

  assert_rxpass_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pass |-> (rec == 7'h7f));

  assert_warn_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.warn == ((int'(tec) >= WARN_LIM) || (int'(rec) >= WARN_LIM)));

  assert_pass_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.pass == ((int'(tec) > 127) || rx_pass));

  assert_boff_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.boff |=> (flags_q.boff && $stable(tec) && $stable(rec)));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(irq_en));

  assert_iid_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3 && pend) |=> (rdata == 16'h8000));
endmodule

bind can_fault_status can_fault_status_chk #(.TX_STEP(TX_STEP), .WARN_LIM(WARN_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_fault(tx_fault), .tec(tec), .rec(rec),
  .rx_pass(rx_pass), .flags_q(flags_q), .pend(pend), .irq_en(irq_en),
  .rd_en(rd_en_i), .addr(addr_i), .rdata(rdata_o)
);

// File: tb/can_fault_status_bench.sv
`timescale 1ns/1ps
module can_fault_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_done_i = 0, rx_done_i = 0, bus_err_i = 0, bus_err_tx_i = 0;
  logic [2:0]  bus_err_code_i = '0;
  logic [15:0] obj_iid_i = '0;
  logic        wr_en_i = 0, rd_en_i = 0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  can_fault_status u_can_fault_status (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
    .bus_err_i(bus_err_i), .bus_err_code_i(bus_err_code_i),
    .bus_err_tx_i(bus_err_tx_i), .obj_iid_i(obj_iid_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Expected state
  int       m_tec, m_rec;
  bit       m_rp, m_boff, m_txok, m_rxok, m_pend, m_sie;
  bit [2:0] m_code;
  bit [15:0] m_rdata;

  function automatic bit [7:0] m_stat();
    bit w, p;
    w = (m_tec >= 96) || (m_rec >= 96);
    p = (m_tec > 127) || m_rp;
    return {m_boff, w, p, m_rxok, m_txok, m_code};
  endfunction

  function automatic bit [15:0] m_read(bit [1:0] a, bit [15:0] obj);
    case (a)
      2'd0:    return {15'd0, m_sie};
      2'd1:    return {8'd0, m_stat()};
      2'd2:    return {m_rp, 7'(m_rec), 8'(m_tec)};
      default: return m_pend ? 16'h8000 : obj;
    endcase
  endfunction

  task automatic m_reset();
    m_tec = 0; m_rec = 0; m_rp = 0; m_boff = 0; m_txok = 0; m_rxok = 0;
    m_pend = 0; m_sie = 0; m_code = 3'd7; m_rdata = '0;
  endtask

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit tx, bit rx, bit er, bit [2:0] c, bit dir,
                     bit wr, bit rd, bit [1:0] a, bit [15:0] wd, bit [15:0] obj);
    bit fv, gt, gr, upd, chg;
    bit [7:0] s0, s1;
    bit [2:0] hc;
    bit [15:0] exp;
    tx_done_i = tx; rx_done_i = rx; bus_err_i = er; bus_err_code_i = c;
    bus_err_tx_i = dir; wr_en_i = wr; rd_en_i = rd; addr_i = a;
    wdata_i = wd; obj_iid_i = obj;
    s0  = m_stat();
    exp = rd ? m_read(a, obj) : m_rdata;
    fv = er && c != 3'd0 && c != 3'd7;
    gt = tx && !fv;
    gr = rx && !fv;
    if (!m_boff) begin
      if (fv && dir) begin
        if (m_tec + 8 > 255) begin m_boff = 1; m_tec = 255; end
        else m_tec += 8;
      end else if (gt && m_tec > 0) m_tec--;
      if (fv && !dir) begin
        if (m_rec == 127) m_rp = 1; else m_rec++;
      end else if (gr) begin
        m_rp = 0;
        if (m_rec > 0) m_rec--;
      end
    end
    upd = fv || gt || gr;
    hc  = fv ? c : 3'd0;
    chg = (gt && !m_txok) || (gr && !m_rxok) || (upd && hc != m_code);
    if (upd) m_code = hc;
    else if (wr && a == 2'd1) m_code = wd[2:0];
    if (gt) m_txok = 1; else if (wr && a == 2'd1 && !wd[3]) m_txok = 0;
    if (gr) m_rxok = 1; else if (wr && a == 2'd1 && !wd[4]) m_rxok = 0;
    s1 = m_stat();
    chg = chg || (s1[7:5] != s0[7:5]);
    m_pend = (m_sie && chg) || (m_pend && !(rd && a == 2'd1));
    if (wr && a == 2'd0) m_sie = wd[0];
    m_rdata = exp;
    @(posedge clk);
    @(negedge clk);
    if (rd) chk(rdata_o, exp, "R13 read data");
    chk({15'd0, irq_o}, {15'd0, (m_pend || obj != 0)}, "R9 irq line");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_done_i = 0; rx_done_i = 0; bus_err_i = 0; wr_en_i = 0; rd_en_i = 0;
    obj_iid_i = '0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic txerr(bit [2:0] c); cyc(0,0,1,c,1,0,0,0,0,0); endtask
  task automatic rxerr(bit [2:0] c); cyc(0,0,1,c,0,0,0,0,0,0); endtask
  task automatic wr(bit [1:0] a, bit [15:0] d); cyc(0,0,0,0,0,1,0,a,d,0); endtask
  task automatic rd_chk(bit [1:0] a, bit [15:0] e, bit [15:0] obj, string tag);
    cyc(0,0,0,0,0,0,1,a,0,obj);
    chk(rdata_o, e, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    rd_chk(0, 16'h0000, 0, "R1 control");
    rd_chk(1, 16'h0007, 0, "R1 status");
    rd_chk(2, 16'h0000, 0, "R1 counters");
    rd_chk(3, 16'h0000, 0, "R1 identifier");
    chk({15'd0, irq_o}, 16'd0, "R1 irq");

    // R2/R4/R11/R10 warning and interrupt priority
    wr(0, 16'h0001);
    for (int i = 0; i < 12; i++) txerr(3'd3);
    rd_chk(2, 16'h0060, 0, "R2 tec 96");
    chk({15'd0, irq_o}, 16'd1, "R9 pending");
    rd_chk(3, 16'h8000, 16'd5, "R11 status first");
    rd_chk(1, 16'h0043, 16'd5, "R4 warn status");
    rd_chk(3, 16'h0005, 16'd5, "R11 object id after clear");
    rd_chk(1, 16'h0043, 0, "R10 read cleared");
    chk({15'd0, irq_o}, 16'd0, "R10 irq low");
    for (int i = 0; i < 4; i++) txerr(3'd3);
    rd_chk(1, 16'h0063, 0, "R5 tx passive");

    // R2/R5/R8/R3 receive side
    do_reset();
    for (int i = 0; i < 130; i++) rxerr(3'd1);
    rd_chk(2, 16'hFF00, 0, "R8 counter layout");
    rd_chk(1, 16'h0061, 0, "R5 rx passive");
    cyc(0,1,0,0,0,0,0,0,0,0);
    rd_chk(2, 16'h7E00, 0, "R3 rx good");
    rd_chk(1, 16'h0050, 0, "R3 rxok status");

    // R7 software writes
    wr(1, 16'h0007);
    rd_chk(1, 16'h0047, 0, "R7 clear and marker");
    cyc(1,0,0,0,0,0,0,0,0,0);
    rd_chk(1, 16'h0048, 0, "R3 txok code0");
    wr(1, 16'h00FF);
    rd_chk(1, 16'h004F, 0, "R7 write ones");
    wr(1, 16'h0000);
    rd_chk(1, 16'h0040, 0, "R7 write zeros");

    // R6 bus-off
    do_reset();
    for (int i = 0; i < 32; i++) txerr(3'd5);
    rd_chk(1, 16'h00E5, 0, "R6 busoff status");
    rd_chk(2, 16'h00FF, 0, "R6 tec 255");
    cyc(1,0,0,0,0,0,0,0,0,0);
    rxerr(3'd2);
    rd_chk(2, 16'h00FF, 0, "R6 frozen");

    // R12 qualification
    do_reset();
    cyc(1,0,1,3'd2,1,0,0,0,0,0);
    rd_chk(2, 16'h0008, 0, "R12 fault wins count");
    rd_chk(1, 16'h0002, 0, "R12 fault wins status");
    cyc(1,0,1,3'd0,1,0,0,0,0,0);
    rd_chk(1, 16'h0008, 0, "R12 code0 ignored");
    cyc(1,0,1,3'd7,1,0,0,0,0,0);
    rd_chk(2, 16'h0006, 0, "R12 code7 ignored");

    // R9 gating and same-code
    do_reset();
    txerr(3'd4);
    chk({15'd0, irq_o}, 16'd0, "R9 disabled");
    wr(0, 16'h0001);
    txerr(3'd2);
    chk({15'd0, irq_o}, 16'd1, "R9 new code");
    rd_chk(1, 16'h0002, 0, "R10 status");
    txerr(3'd2);
    chk({15'd0, irq_o}, 16'd0, "R9 same code");

    // R13 read-only and hold
    wr(2, 16'hFFFF);
    wr(3, 16'hFFFF);
    rd_chk(2, 16'h0018, 0, "R13 ignored write");
    cyc(0,0,0,0,0,0,0,0,0,0);
    chk(rdata_o, 16'h0018, "R13 hold");

    // Constrained random
    do_reset();
    for (int n = 0; n < 20000; n++) begin
      int r;
      bit tx, rx, er, dir, w, rdv;
      bit [2:0] c;
      bit [1:0] a;
      bit [15:0] wd, obj;
      if (n % 400 == 399) do_reset();
      r   = $urandom_range(0, 99);
      tx  = (r < 35);
      rx  = ($urandom_range(0, 99) < 35);
      er  = ($urandom_range(0, 99) < 12);
      c   = 3'($urandom_range(0, 7));
      dir = $urandom_range(0, 1) == 1;
      w   = ($urandom_range(0, 99) < 8);
      rdv = ($urandom_range(0, 99) < 30);
      a   = 2'($urandom_range(0, 3));
      wd  = 16'($urandom());
      if ($urandom_range(0, 1) == 1) wd[2:0] = 3'd7;
      obj = ($urandom_range(0, 9) == 0) ? 16'($urandom_range(1, 32)) : 16'd0;
      cyc(tx, rx, er, c, dir, w, rdv, a, wd, obj);
    end

    summary();
    $finish;
  end
endmodule